// File: doc/BRIEF.md
# Serial Port Interrupt Hub

This block holds the interrupt and flag logic of a simple memory-mapped serial port. It watches the fill levels of the receive and transmit FIFOs, a character-arrival strobe, a bit-period tick, the transmit shifter activity and three modem inputs (clear-to-send, data-set-ready and carrier-detect). From these it builds four interrupt sources: receive, receive timeout, transmit and modem status. Each source has its own enable. A global enable in the control register gates all four into one interrupt line.

Software reaches the block through four word addresses: a control register (read/write), a flag register (read-only), a pending-source register (read-only) and a clear register (write-only). The modem inputs pass through a synchroniser. Any edge on any of them latches a modem status event. That event stays set until software writes any value to the clear register. The serial shifters and the FIFOs sit outside this block and report to it through plain level and strobe inputs.

Top module: `uart_irq_hub`

## Requirements
- R1: After reset the control register reads 0, the pending register reads 0, `irq` is 0 and `uart_en` is 0.
- R2: Address 0 is the control register. Bit 0 is the global enable, bit 1 the receive enable, bit 2 the timeout enable, bit 3 the transmit enable and bit 4 the modem enable. Bits 0 to 4 read back as written, bits 7 to 5 read 0, and `uart_en` follows bit 0.
- R3: Address 1 is the flag register. Bit 0 is clear-to-send, bit 1 data-set-ready and bit 2 carrier-detect, each the synchronised input level. Bit 4 is set when the receive level is 0. Bit 5 is set when the transmit level equals DEPTH. Bits 7 and 6 read 0.
- R4: Flag bit 3 (busy) is set while the transmit level is non-zero or `tx_shifting` is high, so it holds until the last stop bit has left the shifter.
- R5: The receive source is pending while the receive level is at or above DEPTH/2.
- R6: The transmit source is pending while the transmit level is at or below DEPTH/2.
- R7: The timeout source becomes pending once the receive level is non-zero and TMO_BITS `bit_tick` pulses have arrived with no `rx_char` strobe. One tick fewer is not enough. A `rx_char` strobe or an empty receive FIFO clears it.
- R8: A rising or a falling edge on any of the three modem inputs latches the modem source after a two-flop synchroniser.
- R9: A write of any value to address 3 clears the latched modem source. Reading address 3 returns 0.
- R10: Address 2 is the pending register. Bit 0 is modem, bit 1 receive, bit 2 transmit and bit 3 timeout. Each bit is set only when its source is pending, its enable is set and the global enable is set. A read of 0 means nothing is pending, and `irq` is the OR of these bits.
- R11: Writing 0 to the control register clears `uart_en` and holds `irq` low whatever the sources do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data for the address of the previous cycle |
| rx_level | input | 5 | Receive FIFO fill level, 0 to DEPTH |
| tx_level | input | 5 | Transmit FIFO fill level, 0 to DEPTH |
| rx_char | input | 1 | One-cycle pulse when a character enters the receive FIFO |
| bit_tick | input | 1 | One-cycle pulse per serial bit period |
| tx_shifting | input | 1 | Transmit shifter holds a character, stop bits included |
| cts_in | input | 1 | Clear-to-send level, asynchronous |
| dsr_in | input | 1 | Data-set-ready level, asynchronous |
| dcd_in | input | 1 | Carrier-detect level, asynchronous |
| uart_en | output | 1 | Global enable to the rest of the port |
| irq | output | 1 | Registered interrupt request |

## Verification
The checker assumes that the FIFO levels never exceed DEPTH, that `rx_char` and `bit_tick` are single-cycle pulses, and that a modem input change is seen only after the synchroniser has filled following reset. The stimulus honours this. Random levels are drawn only in the range 0 to DEPTH, ticks and strobes are driven as one-cycle pulses, and the modem inputs stay low through reset. During the random phase the modem inputs are held still and the timeout enable is kept off, so the expected pending value depends only on the levels and the control value.

// File: rtl/uis_pkg.sv
package uis_pkg;
  localparam int ADDR_W = 2;
  localparam int NSRC   = 4;
  localparam int CTRL_W = 5;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL = 2'd0,
    A_FLAG = 2'd1,
    A_PEND = 2'd2,
    A_CLR  = 2'd3
  } reg_addr_e;

  // control bit positions
  localparam int C_EN    = 0;
  localparam int C_RXIE  = 1;
  localparam int C_RTOIE = 2;
  localparam int C_TXIE  = 3;
  localparam int C_MSIE  = 4;

  // pending sources, bit 0 = modem
  typedef struct packed {
    logic rto;
    logic tx;
    logic rx;
    logic ms;
  } src_t;
endpackage

// File: rtl/uis_modem_watch.sv
module uis_modem_watch #(
  parameter int N_LINES     = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_LINES-1:0] lines_in,
  input  logic               clr,
  output logic [N_LINES-1:0] lvl,
  output logic               chg,
  output logic               pend
);
  logic [N_LINES-1:0] stage [SYNC_STAGES];
  logic [N_LINES-1:0] prev;
  logic [SYNC_STAGES:0] fill;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SYNC_STAGES; s++) stage[s] <= '0;
    end else begin
      stage[0] <= lines_in;
      for (int s = 1; s < SYNC_STAGES; s++) stage[s] <= stage[s-1];
    end
  end

  assign lvl = stage[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      prev <= '0;
      fill <= '0;
    end else begin
      prev <= lvl;
      fill <= {fill[SYNC_STAGES-1:0], 1'b1};
    end
  end

  assign chg = fill[SYNC_STAGES] && (lvl != prev);

  always_ff @(posedge clk) begin
    if (rst)      pend <= 1'b0;
    else if (chg) pend <= 1'b1;
    else if (clr) pend <= 1'b0;
  end
endmodule

// File: rtl/uis_rx_timer.sv
module uis_rx_timer #(
  parameter int TMO_BITS = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic rx_nonempty,
  input  logic char_stb,
  input  logic bit_tick,
  output logic tmo
);
  localparam int TMO_W = $clog2(TMO_BITS + 1);
  localparam logic [TMO_W-1:0] LIMIT = TMO_W'(TMO_BITS);

  logic [TMO_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !rx_nonempty || char_stb) cnt <= '0;
    else if (bit_tick && cnt != LIMIT) cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) tmo <= 1'b0;
    else     tmo <= rx_nonempty && !char_stb && (cnt == LIMIT);
  end
endmodule

// File: rtl/uis_level_eval.sv
module uis_level_eval #(
  parameter int DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [$clog2(DEPTH+1)-1:0]   rx_level,
  input  logic [$clog2(DEPTH+1)-1:0]   tx_level,
  input  logic                         tx_shifting,
  output logic                         rx_src,
  output logic                         tx_src,
  output logic                         rx_empty,
  output logic                         tx_full,
  output logic                         busy
);
  localparam int LVL_W = $clog2(DEPTH + 1);
  localparam logic [LVL_W-1:0] HALF = LVL_W'(DEPTH / 2);
  localparam logic [LVL_W-1:0] FULL = LVL_W'(DEPTH);

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_src   <= 1'b0;
      tx_src   <= 1'b0;
      rx_empty <= 1'b1;
      tx_full  <= 1'b0;
      busy     <= 1'b0;
    end else begin
      rx_src   <= rx_level >= HALF;
      tx_src   <= tx_level <= HALF;
      rx_empty <= rx_level == '0;
      tx_full  <= tx_level == FULL;
      busy     <= (tx_level != '0) || tx_shifting;
    end
  end
endmodule

// File: rtl/uart_irq_hub.sv
module uart_irq_hub #(
  parameter int DEPTH       = 16,
  parameter int TMO_BITS    = 32,
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W      = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       reg_wr,
  input  logic [1:0]                 reg_addr,
  input  logic [DATA_W-1:0]          reg_wdata,
  output logic [DATA_W-1:0]          reg_rdata,
  input  logic [$clog2(DEPTH+1)-1:0] rx_level,
  input  logic [$clog2(DEPTH+1)-1:0] tx_level,
  input  logic                       rx_char,
  input  logic                       bit_tick,
  input  logic                       tx_shifting,
  input  logic                       cts_in,
  input  logic                       dsr_in,
  input  logic                       dcd_in,
  output logic                       uart_en,
  output logic                       irq
);
  import uis_pkg::*;

  logic [CTRL_W-1:0] ctrl;
  logic [2:0]        mlvl;
  logic              ms_chg, ms_pend, clr_wr;
  logic              rto_raw, rx_raw, tx_raw, rx_empty, tx_full, busy;
  src_t              raw, ie, pend;
  logic [DATA_W-1:0] rd_next;

  assign clr_wr = reg_wr && (reg_addr == A_CLR);

  always_ff @(posedge clk) begin
    if (rst) ctrl <= '0;
    else if (reg_wr && reg_addr == A_CTRL) ctrl <= reg_wdata[CTRL_W-1:0];
  end

  uis_modem_watch #(.N_LINES(3), .SYNC_STAGES(SYNC_STAGES)) i_modem (
    .clk(clk), .rst(rst),
    .lines_in({dcd_in, dsr_in, cts_in}),
    .clr(clr_wr), .lvl(mlvl), .chg(ms_chg), .pend(ms_pend)
  );

  uis_rx_timer #(.TMO_BITS(TMO_BITS)) i_timer (
    .clk(clk), .rst(rst),
    .rx_nonempty(rx_level != '0), .char_stb(rx_char),
    .bit_tick(bit_tick), .tmo(rto_raw)
  );

  uis_level_eval #(.DEPTH(DEPTH)) i_levels (
    .clk(clk), .rst(rst),
    .rx_level(rx_level), .tx_level(tx_level), .tx_shifting(tx_shifting),
    .rx_src(rx_raw), .tx_src(tx_raw),
    .rx_empty(rx_empty), .tx_full(tx_full), .busy(busy)
  );

  always_comb begin
    raw     = '{rto: rto_raw, tx: tx_raw, rx: rx_raw, ms: ms_pend};
    ie      = '{rto: ctrl[C_RTOIE], tx: ctrl[C_TXIE], rx: ctrl[C_RXIE], ms: ctrl[C_MSIE]};
    pend    = raw & ie & {NSRC{ctrl[C_EN]}};
    rd_next = '0;
    case (reg_addr)
      A_CTRL: rd_next[CTRL_W-1:0] = ctrl;
      A_FLAG: rd_next[5:0] = {tx_full, rx_empty, busy, mlvl};
      A_PEND: rd_next[NSRC-1:0] = pend;
      default: rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq       <= 1'b0;
      reg_rdata <= '0;
    end else begin
      irq       <= |pend;
      reg_rdata <= rd_next;
    end
  end

  assign uart_en = ctrl[C_EN];
endmodule

// File: rtl/uis_checker.sv
module uis_checker #(
  parameter int DEPTH = 16
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       reg_wr,
  input logic [1:0]                 reg_addr,
  input logic [$clog2(DEPTH+1)-1:0] rx_level,
  input logic                       tx_shifting,
  input logic                       uart_en,
  input logic                       irq,
  input logic                       ms_chg,
  input logic                       ms_pend,
  input logic                       rto_raw,
  input logic                       busy
);
  AST_MASKED_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    !uart_en |=> !irq); // R11
  AST_CTRL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !(reg_wr && reg_addr == 2'd0) |=> $stable(uart_en)); // R2
  AST_EDGE_LATCHES: assert property (@(posedge clk) disable iff (rst)
    ms_chg |=> ms_pend); // R8
  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == 2'd3 && !ms_chg) |=> !ms_pend); // R9
  AST_TMO_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (rx_level == '0) |=> !rto_raw); // R7
  AST_BUSY_SHIFT: assert property (@(posedge clk) disable iff (rst)
    tx_shifting |=> busy); // R4
endmodule

bind uart_irq_hub uis_checker #(.DEPTH(DEPTH)) i_uis_checker (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .rx_level(rx_level), .tx_shifting(tx_shifting), .uart_en(uart_en),
  .irq(irq), .ms_chg(ms_chg), .ms_pend(ms_pend), .rto_raw(rto_raw), .busy(busy)
);

// File: tb/test_uart_irq_hub.sv
`timescale 1ns/1ps
module test_uart_irq_hub;
  localparam int DEPTH = 16;
  localparam int TMO_BITS = 32;
  localparam int LVL_W = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic [LVL_W-1:0] rx_level = '0, tx_level = '0;
  logic rx_char = 1'b0, bit_tick = 1'b0, tx_shifting = 1'b0;
  logic cts_in = 1'b0, dsr_in = 1'b0, dcd_in = 1'b0;
  logic uart_en, irq;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  uart_irq_hub #(.DEPTH(DEPTH), .TMO_BITS(TMO_BITS)) i_uart_irq_hub (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_level(rx_level),
    .tx_level(tx_level), .rx_char(rx_char), .bit_tick(bit_tick),
    .tx_shifting(tx_shifting), .cts_in(cts_in), .dsr_in(dsr_in),
    .dcd_in(dcd_in), .uart_en(uart_en), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic settle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    @(posedge clk);
    #1 d = reg_rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); bit_tick = 1'b1;
      @(negedge clk); bit_tick = 1'b0;
    end
  endtask

  function automatic logic [7:0] exp_flags(input int rxl, input int txl, input bit sh,
                                           input bit c, input bit ds, input bit dc);
    logic [7:0] f = '0;
    f[0] = c; f[1] = ds; f[2] = dc;
    f[3] = (txl != 0) || sh;
    f[4] = (rxl == 0);
    f[5] = (txl == DEPTH);
    return f;
  endfunction

  function automatic logic [7:0] exp_pend(input int rxl, input int txl,
                                          input logic [4:0] c, input bit ms, input bit rto);
    logic [7:0] p = '0;
    if (c[0]) begin
      p[0] = ms && c[4];
      p[1] = (rxl >= DEPTH / 2) && c[1];
      p[2] = (txl <= DEPTH / 2) && c[3];
      p[3] = rto && c[2];
    end
    return p;
  endfunction

  initial begin
    #(5.0 * 150000);
    n_errors++;
    n_checks++;
    $display("FAIL watchdog: got hung expected done");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'h5eed_1234));
    settle(4);
    rst = 1'b0;
    settle(2);

    // R1 reset state
    rd(2'd0, d); check("R1 ctrl", d, 8'h00);
    rd(2'd2, d); check("R1 pend", d, 8'h00);
    check("R1 irq", irq, 1'b0);
    check("R1 uart_en", uart_en, 1'b0);

    // R2 control readback
    wr(2'd0, 8'hff);
    rd(2'd0, d); check("R2 ctrl mask", d, 8'h1f);
    check("R2 uart_en", uart_en, 1'b1);
    wr(2'd0, 8'h0a);
    rd(2'd0, d); check("R2 ctrl value", d, 8'h0a);
    check("R2 uart_en low", uart_en, 1'b0);

    // R9 clear address reads zero
    rd(2'd3, d); check("R9 read clr", d, 8'h00);

    // R8 modem edges, each line, both directions
    wr(2'd0, 8'h11);
    for (int ln = 0; ln < 3; ln++) begin
      for (int pol = 1; pol >= 0; pol--) begin
        wr(2'd3, 8'h5a);
        settle(2);
        rd(2'd2, d); check("R9 cleared", d, 8'h00);
        @(negedge clk);
        if (ln == 0) cts_in = pol[0];
        if (ln == 1) dsr_in = pol[0];
        if (ln == 2) dcd_in = pol[0];
        settle(6);
        rd(2'd2, d); check("R8 edge latched", d, 8'h01);
        check("R10 irq modem", irq, 1'b1);
      end
    end
    // R3 modem levels in flags
    cts_in = 1'b1; dcd_in = 1'b1; dsr_in = 1'b0;
    settle(6);
    rd(2'd1, d); check("R3 flags modem", d, exp_flags(0, 0, 0, 1, 0, 1));
    wr(2'd3, 8'h00);
    settle(2);
    rd(2'd2, d); check("R9 zero write clears", d, 8'h00);
    check("R9 irq low", irq, 1'b0);

    // R4 busy held by shifter with empty FIFO
    tx_shifting = 1'b1; settle(3);
    rd(2'd1, d); check("R4 busy shifting", d[3], 1'b1);
    tx_shifting = 1'b0; settle(3);
    rd(2'd1, d); check("R4 busy idle", d[3], 1'b0);

    // R5/R6 thresholds
    wr(2'd0, 8'h0b);
    rx_level = LVL_W'(DEPTH/2 - 1); tx_level = LVL_W'(DEPTH/2 + 1); settle(3);
    rd(2'd2, d); check("R5 R6 below/above half", d, 8'h00);
    rx_level = LVL_W'(DEPTH/2); tx_level = LVL_W'(DEPTH/2); settle(3);
    rd(2'd2, d); check("R5 R6 at half", d, 8'h06);
    rx_level = LVL_W'(DEPTH); tx_level = LVL_W'(DEPTH); settle(3);
    rd(2'd1, d); check("R3 full flags", d, exp_flags(DEPTH, DEPTH, 0, 1, 0, 1));

    // R11 zero control masks everything
    rx_level = LVL_W'(DEPTH); tx_level = '0; settle(3);
    wr(2'd0, 8'h00); settle(2);
    rd(2'd2, d); check("R11 pend masked", d, 8'h00);
    check("R11 irq masked", irq, 1'b0);
    check("R11 uart_en", uart_en, 1'b0);

    // R7 receive timeout
    wr(2'd0, 8'h05);
    tx_level = LVL_W'(DEPTH); rx_level = 5'd3;
    @(negedge clk); rx_char = 1'b1; @(negedge clk); rx_char = 1'b0;
    ticks(TMO_BITS - 1); settle(3);
    rd(2'd2, d); check("R7 one tick short", d, 8'h00);
    ticks(1); settle(3);
    rd(2'd2, d); check("R7 timeout", d, 8'h08);
    check("R7 irq", irq, 1'b1);
    @(negedge clk); rx_char = 1'b1; @(negedge clk); rx_char = 1'b0;
    settle(3);
    rd(2'd2, d); check("R7 char clears", d, 8'h00);
    ticks(TMO_BITS); settle(3);
    rd(2'd2, d); check("R7 timeout again", d, 8'h08);
    rx_level = '0; settle(3);
    rd(2'd2, d); check("R7 empty clears", d, 8'h00);

    // random phase: modem still, timeout enable off, ms cleared
    wr(2'd3, 8'h01);
    for (int it = 0; it < 300; it++) begin
      int rl, tl;
      bit sh;
      logic [4:0] c;
      rl = $urandom_range(DEPTH, 0);
      tl = $urandom_range(DEPTH, 0);
      sh = 1'($urandom_range(1, 0));
      c  = 5'($urandom_range(31, 0)) & 5'b11011;
      wr(2'd0, {3'b0, c});
      rx_level = LVL_W'(rl); tx_level = LVL_W'(tl); tx_shifting = sh;
      settle(3);
      rd(2'd1, d); check("R3 R4 random flags", d, exp_flags(rl, tl, sh, 1, 0, 1));
      rd(2'd2, d); check("R10 random pend", d, exp_pend(rl, tl, c, 0, 0));
      check("R10 random irq", irq, |exp_pend(rl, tl, c, 0, 0));
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule